// File: doc/BRIEF.md
# Shadow Stack Return Checker

This block keeps a private hardware copy of return addresses so that every function return can be validated against the call that led to it. It watches the retire stream of a 32-bit core: each retired instruction arrives with its instruction word, its own PC and the PC that follows it. When a retired instruction is a call that links through x1, the block pushes PC+4 onto an on-chip LIFO. When a retired instruction is a return, the block pops the top entry and compares it with the next PC that the return is about to use.

The comparison takes one extra cycle. During that cycle a stall output is raised so that the pipeline holds back the next retirement. A mismatch, a return on an empty stack or a call on a full stack each raise a sticky flag. A synchronous clear drops all flags and empties the stack. A jump that does not link (rd = x0) pushes nothing. A tail-jump between functions therefore leaves the original caller's address on top for the eventual return.

Top module: `ret_guard`

## Requirements
- R1: A retired instruction is a call when its opcode (bits 6:0) is 1101111, or when its opcode is 1100111 with funct3 (bits 14:12) equal to 000, and in both cases rd (bits 11:7) equals 1. A call pushes its PC+4 onto the shadow stack.
- R2: A retired instruction is a return when its opcode is 1100111, funct3 is 000, rd is 0, rs1 (bits 19:15) is 1 and the immediate (bits 31:20) is 0. Its next PC is compared with the top of the stack.
- R3: A return whose next PC equals the top entry raises no flag. A return whose next PC differs sets ret_viol_o.
- R4: stall_o is high for exactly the one cycle after a return retires. The return's flags are visible in the cycle after that.
- R5: Every return that finds the stack non-empty pops one entry, whether or not it matched.
- R6: A jump with rd = 0 (a tail-jump) and any instruction that is neither a call nor a return leave the stack unchanged.
- R7: The stack holds DEPTH (16) entries. A call when the stack is full sets ovf_o and discards the new address, and the 16 stored entries are kept.
- R8: A return when the stack is empty sets both udf_o and ret_viol_o.
- R9: All three flags stay set until clr_i is sampled high. clr_i clears the flags and empties the stack at the same clock edge.
- R10: After rst_ni is asserted, all flags and stall_o are low and the stack is empty.
- R11: An instruction presented while retire_valid_i is low has no effect on the stack or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of flags and stack |
| retire_valid_i | input | 1 | Retire strobe |
| retire_insn_i | input | 32 | Retired instruction word |
| retire_pc_i | input | 32 | PC of the retired instruction |
| retire_npc_i | input | 32 | Next PC after the retired instruction |
| ret_viol_o | output | 1 | Sticky return violation flag |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |
| stall_o | output | 1 | Holds retirement while a return check is in progress |

## Verification
The assertions assume that the core honours stall_o: no retire strobe and no clear is presented in the cycle where stall_o is high, so a push and a pop never meet at the same edge. The stimulus respects this. It waits out the check cycle after every return before it drives the next instruction, and it issues clears only with the retire strobe low. Random sequences mix calls, matching and corrupted returns, tail-jumps and ordinary instructions. They are deep enough to reach overflow and underflow, which are also driven as directed cases.

// File: rtl/ret_guard_pkg.sv
package ret_guard_pkg;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;
  localparam logic [4:0] REG_LINK = 5'd1;
  localparam logic [4:0] REG_ZERO = 5'd0;

  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_CALL  = 2'd1,
    K_RET   = 2'd2
  } insn_kind_e;
endpackage

// File: rtl/ret_guard_decode.sv
module ret_guard_decode
  import ret_guard_pkg::*;
(
  input  logic [31:0] insn_i,
  output insn_kind_e  kind_o
);
  logic [6:0]  opc;
  logic [4:0]  rd, rs1;
  logic [2:0]  f3;
  logic [11:0] imm;
  logic        is_jal, is_jalr;

  assign opc = insn_i[6:0];
  assign rd  = insn_i[11:7];
  assign f3  = insn_i[14:12];
  assign rs1 = insn_i[19:15];
  assign imm = insn_i[31:20];

  assign is_jal  = (opc == OP_JAL);
  assign is_jalr = (opc == OP_JALR) && (f3 == 3'b000);

  always_comb begin
    kind_o = K_OTHER;
    if ((is_jal || is_jalr) && rd == REG_LINK)
      kind_o = K_CALL;
    else if (is_jalr && rd == REG_ZERO && rs1 == REG_LINK && imm == 12'd0)
      kind_o = K_RET;
  end
endmodule

// File: rtl/ret_guard_stack.sv
module ret_guard_stack #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CW-1:0]    cnt_q;
  logic [AW-1:0]    wr_idx, top_idx;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_idx  = AW'(cnt_q);
  assign top_idx = AW'(cnt_q - 1'b1);
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!clr_i && !pop_i && push_i && !full_o) mem_q[wr_idx] <= data_i;
  end

  a_r7_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clr_i && full_o) |=> $stable(cnt_q));
  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clr_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r5_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/ret_guard.sv
module ret_guard
  import ret_guard_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int XLEN  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            retire_valid_i,
  input  logic [31:0]     retire_insn_i,
  input  logic [XLEN-1:0] retire_pc_i,
  input  logic [XLEN-1:0] retire_npc_i,
  output logic            ret_viol_o,
  output logic            ovf_o,
  output logic            udf_o,
  output logic            stall_o
);
  localparam logic [XLEN-1:0] LINK_OFS = XLEN'(4);

  insn_kind_e      kind;
  logic            accept, push, pop;
  logic            chk_pend_q;
  logic [XLEN-1:0] chk_tgt_q, top;
  logic            full, empty;

  ret_guard_decode u_dec (
    .insn_i (retire_insn_i),
    .kind_o (kind)
  );

  // retirement is held off while a check is pending
  assign accept = retire_valid_i && !chk_pend_q && !clr_i;
  assign push   = accept && (kind == K_CALL);
  assign pop    = chk_pend_q && !clr_i;

  ret_guard_stack #(.DEPTH(DEPTH), .WIDTH(XLEN)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .push_i  (push),
    .pop_i   (pop),
    .data_i  (retire_pc_i + LINK_OFS),
    .top_o   (top),
    .full_o  (full),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_pend_q <= 1'b0;
      chk_tgt_q  <= '0;
    end else if (clr_i) begin
      chk_pend_q <= 1'b0;
    end else begin
      chk_pend_q <= accept && (kind == K_RET);
      if (accept && kind == K_RET) chk_tgt_q <= retire_npc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_viol_o <= 1'b0;
      ovf_o      <= 1'b0;
      udf_o      <= 1'b0;
    end else if (clr_i) begin
      ret_viol_o <= 1'b0;
      ovf_o      <= 1'b0;
      udf_o      <= 1'b0;
    end else begin
      if (push && full) ovf_o <= 1'b1;
      if (chk_pend_q) begin
        if (empty) begin
          udf_o      <= 1'b1;
          ret_viol_o <= 1'b1;
        end else if (top != chk_tgt_q) begin
          ret_viol_o <= 1'b1;
        end
      end
    end
  end

  assign stall_o = chk_pend_q;

  a_r4_stall_after_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_valid_i && !stall_o && !clr_i && kind == K_RET) |=> stall_o);
  a_r4_stall_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  a_r8_udf_implies_viol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |-> ret_viol_o);
  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
  a_r9_viol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_viol_o && !clr_i) |=> ret_viol_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!ret_viol_o && !ovf_o && !udf_o && !stall_o));
endmodule

// File: tb/ret_guard_bench.sv
module ret_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] insn = '0, pc = '0, npc = '0;
  logic        viol, ovf, udf, stall;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_stk [16];
  int          m_cnt = 0;
  logic        m_viol = 0, m_ovf = 0, m_udf = 0;

  always #5 clk = ~clk;

  ret_guard u_ret_guard (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .retire_valid_i(valid),
    .retire_insn_i(insn), .retire_pc_i(pc), .retire_npc_i(npc),
    .ret_viol_o(viol), .ovf_o(ovf), .udf_o(udf), .stall_o(stall)
  );

  function automatic logic [31:0] enc_jal(input logic [4:0] rd);
    return {20'h00010, rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                           input logic [11:0] imm);
    return {imm, rs1, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] enc_addi();
    return {12'd5, 5'd2, 3'b000, 5'd2, 7'b0010011};
  endfunction
  function automatic bit m_is_call(input logic [31:0] w);
    return (w[11:7] == 5'd1) && (w[6:0] == 7'b1101111 ||
           (w[6:0] == 7'b1100111 && w[14:12] == 3'b000));
  endfunction
  function automatic bit m_is_ret(input logic [31:0] w);
    return w[6:0] == 7'b1100111 && w[14:12] == 3'b000 && w[11:7] == 5'd0 &&
           w[19:15] == 5'd1 && w[31:20] == 12'd0;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " viol"}, viol, m_viol);
    chk({tag, " ovf"},  ovf,  m_ovf);
    chk({tag, " udf"},  udf,  m_udf);
    chk({tag, " stall"}, stall, 1'b0);
  endtask

  task automatic retire(input logic v, input logic [31:0] w, input logic [31:0] p,
                        input logic [31:0] n);
    @(negedge clk);
    valid = v; insn = w; pc = p; npc = n;
    @(negedge clk);
    valid = 1'b0;
    if (v && m_is_ret(w)) begin
      chk("R4 stall during check", stall, 1'b1);
      @(negedge clk);
    end
    if (v) begin
      if (m_is_call(w)) begin
        if (m_cnt == 16) m_ovf = 1;
        else begin m_stk[m_cnt] = p + 32'd4; m_cnt++; end
      end else if (m_is_ret(w)) begin
        if (m_cnt == 0) begin m_udf = 1; m_viol = 1; end
        else begin
          if (m_stk[m_cnt-1] != n) m_viol = 1;
          m_cnt--;
        end
      end
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_cnt = 0; m_viol = 0; m_ovf = 0; m_udf = 0;
  endtask

  function automatic logic [31:0] rpc();
    logic [31:0] r = $urandom;
    return {r[31:2], 2'b00};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset viol", viol, 0); chk("R10 reset ovf", ovf, 0);
    chk("R10 reset udf", udf, 0);   chk("R10 reset stall", stall, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R6: call, tail-jump, return to original caller
    retire(1, enc_jal(5'd1), 32'h100, 32'h200);
    retire(1, enc_jal(5'd0), 32'h2f0, 32'h300);
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h340, 32'h104);
    chk_flags("R6 tail-jump return matches");
    // R6: stack empty again -> another ret underflows
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h400, 32'h104);
    chk_flags("R8 underflow after tail path");
    chk("R8 udf set", udf, 1'b1);
    do_clr();
    chk_flags("R9 cleared");

    // R1: jalr rd=1 pushes; R5: pop on mismatch keeps alignment
    retire(1, enc_jalr(5'd1, 5'd5, 12'd0), 32'h1000, 32'h5000);
    retire(1, enc_jal(5'd1), 32'h5000, 32'h6000);
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h6010, 32'hdead0);
    chk_flags("R3 mismatch");
    chk("R3 viol on mismatch", viol, 1'b1);
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h5010, 32'h1004);
    chk_flags("R5 second ret no underflow");
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h1010, 32'h1004);
    chk_flags("R5 third ret underflows");
    do_clr();

    // R11: invalid call ignored, R2: jalr with nonzero imm is not a ret
    retire(0, enc_jal(5'd1), 32'h700, 32'h800);
    retire(1, enc_jalr(5'd0, 5'd1, 12'd4), 32'h710, 32'h704);
    chk_flags("R2 non-ret jalr ignored");
    retire(0, enc_jalr(5'd0, 5'd1, 12'd0), 32'h720, 32'h704);
    chk_flags("R11 invalid ret ignored");
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h730, 32'h704);
    chk_flags("R11 stack empty after invalid call");
    chk("R11 udf", udf, 1'b1);
    do_clr();

    // R7: overflow keeps 16 entries
    for (int i = 0; i < 17; i++) retire(1, enc_jal(5'd1), 32'h100 * (i + 1), 32'h0);
    chk_flags("R7 overflow");
    chk("R7 ovf set", ovf, 1'b1);
    for (int i = 15; i >= 0; i--)
      retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h0, 32'h100 * (i + 1) + 32'd4);
    chk_flags("R7 stored entries intact");
    chk("R7 no viol", viol, 1'b0);
    retire(1, enc_jalr(5'd0, 5'd1, 12'd0), 32'h0, 32'h1104);
    chk_flags("R8 empty after 16");
    retire(1, enc_addi(), 32'h0, 32'h4);
    chk_flags("R9 flags sticky");
    do_clr();

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 20;
      logic [31:0] p = rpc();
      if (r < 7)       retire(1, enc_jal(5'd1), p, rpc());
      else if (r < 8)  retire(1, enc_jalr(5'd1, 5'd7, 12'd8), p, rpc());
      else if (r < 14) begin
        logic [31:0] t = (m_cnt > 0 && ($urandom % 6) != 0) ? m_stk[m_cnt-1] : rpc();
        retire(1, enc_jalr(5'd0, 5'd1, 12'd0), p, t);
      end
      else if (r < 16) retire(1, enc_jal(5'd0), p, rpc());
      else if (r < 18) retire($urandom % 2, enc_addi(), p, p + 4);
      else if (r < 19) retire(0, enc_jal(5'd1), p, rpc());
      else             do_clr();
      chk_flags("R1 R2 R3 R5 R7 R8 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule